// File: doc/BRIEF.md
# CRC-Checked Burst Transfer Gate

This block sits between a serial command front end and a byte-wide memory array and guards bulk transfers with a 16-bit checksum. For a guarded write, the front end raises `start_wr` and then pushes three address bytes, a fixed-length payload and two checksum bytes through a byte handshake. The gate keeps the payload in a private staging buffer while it runs the checksum over address and payload. Only when its own result equals the received checksum does it copy the staged bytes to memory, one per cycle. Otherwise it writes nothing and raises a sticky error flag.

For a guarded read, the front end raises `start_rd` and passes the bytes it fetches from the array into the gate. The gate forwards each byte unchanged to the output handshake, runs the checksum over them as they pass, and then appends the two checksum bytes. Deselecting the device (`cs_n` high) during either transfer abandons it.

States: `ST_IDLE` (waits for a start command), `ST_W_ADDR` (collects address bytes), `ST_W_DATA` (stages payload), `ST_W_CRC` (collects the received checksum), `ST_W_CHECK` (compares, one cycle), `ST_W_COMMIT` (copies the buffer to memory), `ST_R_DATA` (forwards read bytes), `ST_R_CRC_HI` and `ST_R_CRC_LO` (send the checksum). Transitions: IDLE to W_ADDR on `start_wr`, or to R_DATA on `start_rd`, while selected; W_ADDR to W_DATA after the last address byte; W_DATA to W_CRC after the last payload byte; W_CRC to W_CHECK after the second checksum byte; W_CHECK to W_COMMIT on a match, or to IDLE on a mismatch; W_COMMIT to IDLE after the last byte is written; R_DATA to R_CRC_HI after the last payload byte; R_CRC_HI to R_CRC_LO and R_CRC_LO to IDLE as each checksum byte is taken; W_ADDR, W_DATA, W_CRC and every read state to IDLE when `cs_n` is high.

Top module: `crc_burst_gate`

## Requirements
- R1: The checksum uses polynomial 0x1021, start value 0xFFFF, no bit reflection and no final inversion. Each byte is fed most significant bit first. A write checksum covers the three address bytes, sent most significant byte first, followed by the 128 payload bytes. The received checksum arrives high byte first.
- R2: On a checksum match, payload byte k (k = 0..127) is written to memory address base+k, in ascending order, one byte per cycle with no gaps.
- R3: On a checksum mismatch, no memory write occurs and `crc_err` goes to 1.
- R4: A corrupted address byte, with an unchanged payload and a checksum computed over the intended address, counts as a mismatch and blocks every write.
- R5: `crc_err` stays set until a successful guarded write or a one-cycle `clr_err` pulse clears it. If a mismatch and `clr_err` fall on the same cycle, the mismatch wins.
- R6: If `cs_n` rises before all 133 write bytes have arrived, the staged write is dropped. No memory write happens and `crc_err` keeps its value.
- R7: `busy` is high for exactly the 128 cycles of the memory copy, and `in_ready` is low throughout that copy.
- R8: During a guarded read, each of the 128 input bytes appears unchanged on `out_data`. The checksum of those 128 bytes follows them, high byte first.
- R9: After reset the gate is idle: `busy`, `crc_err`, `mem_we`, `out_valid` and `in_ready` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Device select, active low; high abandons a transfer |
| start_wr | input | 1 | Begin a guarded write (accepted in idle) |
| start_rd | input | 1 | Begin a guarded read (accepted in idle) |
| clr_err | input | 1 | Clear the sticky error flag |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte |
| in_ready | output | 1 | Gate accepts the input byte |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Output byte |
| out_ready | input | 1 | Consumer accepts the output byte |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | 24 | Memory write address |
| mem_wdata | output | 8 | Memory write data |
| busy | output | 1 | Staged bytes are being copied to memory |
| crc_err | output | 1 | Sticky checksum-mismatch flag |

## Verification
If the byte counter drifts, the fault shows at the ports on the transfer it affects. It surfaces as a checksum mismatch and a raised `crc_err` one cycle after the last checksum byte, or as a wrong address on the first `mem_we` of the copy. A corrupted checksum register is visible on the read path two cycles after the last forwarded byte, as a wrong trailing byte. A staging-buffer fault only appears during the copy, as a wrong `mem_wdata` at offset k, k+1 cycles after the copy begins. A state machine stuck in the copy shows as `busy` held past 128 cycles, with `in_ready` low.

// File: rtl/cbg_pkg.sv
package cbg_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_W_ADDR,
        ST_W_DATA,
        ST_W_CRC,
        ST_W_CHECK,
        ST_W_COMMIT,
        ST_R_DATA,
        ST_R_CRC_HI,
        ST_R_CRC_LO
    } gate_state_e;

    localparam logic [15:0] CRC_POLY = 16'h1021;
    localparam logic [15:0] CRC_SEED = 16'hFFFF;

    // One byte of CRC update, bits taken most significant first.
    function automatic logic [15:0] crc16_byte(input logic [15:0] c, input logic [7:0] d);
        logic [15:0] r;
        r = c;
        for (int i = 7; i >= 0; i--) begin
            if (r[15] ^ d[i]) r = (r << 1) ^ CRC_POLY;
            else              r = r << 1;
        end
        return r;
    endfunction

endpackage

// File: rtl/cbg_crc_acc.sv
module cbg_crc_acc
    import cbg_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        init,
    input  logic        en,
    input  logic [7:0]  din,
    output logic [15:0] crc
);
    always_ff @(posedge clk) begin
        if (!rst_n || init) crc <= CRC_SEED;
        else if (en)        crc <= crc16_byte(crc, din);
    end
endmodule

// File: rtl/cbg_stage_buf.sv
module cbg_stage_buf #(
    parameter int DEPTH = 128,
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [IW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [IW-1:0] raddr,
    output logic [7:0]    rdata
);
    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/crc_burst_gate.sv
module crc_burst_gate
    import cbg_pkg::*;
#(
    parameter int ADDR_BYTES    = 3,
    parameter int PAYLOAD_BYTES = 128
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cs_n,
    input  logic                    start_wr,
    input  logic                    start_rd,
    input  logic                    clr_err,
    input  logic                    in_valid,
    input  logic [7:0]              in_data,
    output logic                    in_ready,
    output logic                    out_valid,
    output logic [7:0]              out_data,
    input  logic                    out_ready,
    output logic                    mem_we,
    output logic [ADDR_BYTES*8-1:0] mem_addr,
    output logic [7:0]              mem_wdata,
    output logic                    busy,
    output logic                    crc_err
);
    localparam int AW_BITS = ADDR_BYTES * 8;
    localparam int CW      = $clog2(PAYLOAD_BYTES + 1);
    localparam int BW      = $clog2(PAYLOAD_BYTES);
    localparam logic [CW-1:0] LAST_ADDR = CW'(ADDR_BYTES - 1);
    localparam logic [CW-1:0] LAST_DATA = CW'(PAYLOAD_BYTES - 1);
    localparam logic [CW-1:0] LAST_CRC  = CW'(1);

    gate_state_e state, nxt;
    logic [CW-1:0]      cnt;
    logic [AW_BITS-1:0] base;
    logic [15:0]        rx_crc;
    logic [15:0]        crc;
    logic [7:0]         buf_rdata;
    logic               err_q;
    logic               in_fire;
    logic               crc_en;

    assign in_fire = in_valid && in_ready;
    assign crc_en  = in_fire && (state == ST_W_ADDR || state == ST_W_DATA || state == ST_R_DATA);

    cbg_crc_acc u_crc (
        .clk  (clk),
        .rst_n(rst_n),
        .init (state == ST_IDLE),
        .en   (crc_en),
        .din  (in_data),
        .crc  (crc)
    );

    cbg_stage_buf #(.DEPTH(PAYLOAD_BYTES)) u_buf (
        .clk  (clk),
        .we   (in_fire && state == ST_W_DATA),
        .waddr(cnt[BW-1:0]),
        .wdata(in_data),
        .raddr(cnt[BW-1:0]),
        .rdata(buf_rdata)
    );

    // Next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:     if (!cs_n && start_wr) nxt = ST_W_ADDR;
                         else if (!cs_n && start_rd) nxt = ST_R_DATA;
            ST_W_ADDR:   if (cs_n) nxt = ST_IDLE;
                         else if (in_fire && cnt == LAST_ADDR) nxt = ST_W_DATA;
            ST_W_DATA:   if (cs_n) nxt = ST_IDLE;
                         else if (in_fire && cnt == LAST_DATA) nxt = ST_W_CRC;
            ST_W_CRC:    if (cs_n) nxt = ST_IDLE;
                         else if (in_fire && cnt == LAST_CRC) nxt = ST_W_CHECK;
            ST_W_CHECK:  nxt = (crc == rx_crc) ? ST_W_COMMIT : ST_IDLE;
            ST_W_COMMIT: if (cnt == LAST_DATA) nxt = ST_IDLE;
            ST_R_DATA:   if (cs_n) nxt = ST_IDLE;
                         else if (in_fire && cnt == LAST_DATA) nxt = ST_R_CRC_HI;
            ST_R_CRC_HI: if (cs_n) nxt = ST_IDLE;
                         else if (out_ready) nxt = ST_R_CRC_LO;
            ST_R_CRC_LO: if (cs_n || out_ready) nxt = ST_IDLE;
            default:     nxt = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= '0;
            base   <= '0;
            rx_crc <= '0;
            err_q  <= 1'b0;
        end else begin
            if (nxt != state)                          cnt <= '0;
            else if (in_fire || state == ST_W_COMMIT)  cnt <= cnt + 1'b1;
            if (in_fire && state == ST_W_ADDR) base   <= {base[AW_BITS-9:0], in_data};
            if (in_fire && state == ST_W_CRC)  rx_crc <= {rx_crc[7:0], in_data};
            if (state == ST_W_CHECK) err_q <= (crc != rx_crc);
            else if (clr_err)        err_q <= 1'b0;
        end
    end

    // Outputs
    always_comb begin
        in_ready  = 1'b0;
        out_valid = 1'b0;
        out_data  = in_data;
        unique case (state)
            ST_W_ADDR, ST_W_DATA, ST_W_CRC: in_ready = !cs_n;
            ST_R_DATA: begin
                in_ready  = out_ready && !cs_n;
                out_valid = in_valid && !cs_n;
            end
            ST_R_CRC_HI: begin
                out_valid = 1'b1;
                out_data  = crc[15:8];
            end
            ST_R_CRC_LO: begin
                out_valid = 1'b1;
                out_data  = crc[7:0];
            end
            default: ;
        endcase
    end

    assign busy      = (state == ST_W_COMMIT);
    assign mem_we    = busy;
    assign mem_addr  = base + AW_BITS'(cnt);
    assign mem_wdata = buf_rdata;
    assign crc_err   = err_q;

endmodule

// File: rtl/crc_burst_gate_chk.sv
module crc_burst_gate_chk #(
    parameter int AW_BITS = 24
) (
    input logic               clk,
    input logic               rst_n,
    input logic               clr_err,
    input logic               in_ready,
    input logic               busy,
    input logic               mem_we,
    input logic [AW_BITS-1:0] mem_addr,
    input logic               crc_err
);
    // R7
    busy_no_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !in_ready);

    // R2
    commit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && $past(mem_we)) |-> (mem_addr == $past(mem_addr) + AW_BITS'(1)));

    // R3
    err_set_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(crc_err) |-> (!mem_we && !busy));

    // R5
    err_clear_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(crc_err) |-> ($past(clr_err) || busy));
endmodule

bind crc_burst_gate crc_burst_gate_chk #(.AW_BITS(ADDR_BYTES * 8)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_err (clr_err),
    .in_ready(in_ready),
    .busy    (busy),
    .mem_we  (mem_we),
    .mem_addr(mem_addr),
    .crc_err (crc_err)
);

// File: tb/crc_burst_gate_tb.sv
`timescale 1ns/1ps
module crc_burst_gate_tb;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        cs_n = 1, start_wr = 0, start_rd = 0, clr_err = 0;
    logic        in_valid = 0, out_ready = 1;
    logic [7:0]  in_data = 0;
    logic        in_ready, out_valid, mem_we, busy, crc_err;
    logic [7:0]  out_data, mem_wdata;
    logic [23:0] mem_addr;

    crc_burst_gate u_dut (.*);

    always #2 clk = ~clk;

    int n_chk = 0, n_fail = 0;
    bit done = 0;
    int wr_cnt, wr_bad, rd_cnt;
    logic [23:0] exp_base;
    logic [7:0]  exp_data [128];
    logic [7:0]  rd_buf [130];

    // kind: 0 good write, 1 bad checksum, 2 deselect abort, 3 corrupt address, 4 read
    // {kind[3:0], expected crc_err, base[23:0], seed[7:0]}
    localparam logic [36:0] CASES [6] = '{
        {4'd0, 1'b0, 24'h000100, 8'h11},
        {4'd1, 1'b1, 24'h001200, 8'h5A},
        {4'd2, 1'b1, 24'h000300, 8'h07},
        {4'd0, 1'b0, 24'h01FF80, 8'hC3},
        {4'd3, 1'b1, 24'h000400, 8'h22},
        {4'd4, 1'b1, 24'h000000, 8'h9E}
    };

    function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [7:0] b);
        logic [15:0] r = c;
        for (int i = 0; i < 8; i++) begin
            logic fb = r[15] ^ b[7-i];
            r = {r[14:0], 1'b0};
            if (fb) r = r ^ 16'h1021;
        end
        return r;
    endfunction

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        #1;
        if (mem_we) begin
            if (wr_cnt > 127 || mem_addr !== exp_base + 24'(wr_cnt) || mem_wdata !== exp_data[wr_cnt[6:0]])
                wr_bad++;
            wr_cnt++;
        end
        if (out_valid && out_ready && rd_cnt < 130) begin
            rd_buf[rd_cnt] = out_data;
            rd_cnt++;
        end
    end

    task automatic send_byte(logic [7:0] b);
        in_valid = 1;
        in_data  = b;
        forever begin
            if (in_ready) begin
                @(negedge clk);
                break;
            end
            @(negedge clk);
        end
        in_valid = 0;
    endtask

    task automatic pulse_start(bit rd);
        if (rd) start_rd = 1; else start_wr = 1;
        @(negedge clk);
        start_rd = 0;
        start_wr = 0;
    endtask

    task automatic wait_cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic run_case(logic [36:0] v);
        logic [3:0]  kind = v[36:33];
        logic        eerr = v[32];
        logic [23:0] base = v[31:8];
        logic [7:0]  seed = v[7:0];
        logic [15:0] c = 16'hFFFF;
        int bad = 0;
        wr_cnt = 0; wr_bad = 0; rd_cnt = 0; exp_base = base;
        for (int k = 0; k < 128; k++) exp_data[k] = seed + 8'(k * 7) ^ 8'(k >> 3);
        if (kind == 4) begin
            pulse_start(1);
            for (int k = 0; k < 128; k++) begin
                c = ref_crc(c, exp_data[k]);
                send_byte(exp_data[k]);
            end
            wait_cyc(4);
            chk("R8", "read byte count", rd_cnt, 130);
            for (int k = 0; k < 128; k++) if (rd_buf[k] !== exp_data[k]) bad++;
            chk("R8", "forwarded byte mismatches", bad, 0);
            chk("R8", "read checksum", {rd_buf[128], rd_buf[129]}, c);
            chk("R8", "read causes no write", wr_cnt, 0);
            chk("R5", "crc_err after read", crc_err, eerr);
            return;
        end
        for (int i = 2; i >= 0; i--) c = ref_crc(c, base[i*8 +: 8]);
        for (int k = 0; k < 128; k++) c = ref_crc(c, exp_data[k]);
        pulse_start(0);
        send_byte(base[23:16]);
        send_byte(base[15:8]);
        send_byte(kind == 3 ? base[7:0] ^ 8'h01 : base[7:0]);
        if (kind == 2) begin
            for (int k = 0; k < 40; k++) send_byte(exp_data[k]);
            cs_n = 1;
            wait_cyc(2);
            cs_n = 0;
            wait_cyc(4);
            chk("R6", "writes after abort", wr_cnt, 0);
            chk("R6", "crc_err kept after abort", crc_err, eerr);
            return;
        end
        for (int k = 0; k < 128; k++) send_byte(exp_data[k]);
        send_byte(c[15:8]);
        send_byte(kind == 1 ? c[7:0] ^ 8'h01 : c[7:0]);
        wait_cyc(140);
        case (kind)
            0: begin
                chk("R2", "write count on match", wr_cnt, 128);
                chk("R1", "address/data mismatches", wr_bad, 0);
                chk("R5", "crc_err cleared by good write", crc_err, eerr);
            end
            1: begin
                chk("R3", "write count on bad checksum", wr_cnt, 0);
                chk("R3", "crc_err on bad checksum", crc_err, eerr);
            end
            default: begin
                chk("R4", "write count on corrupt address", wr_cnt, 0);
                chk("R4", "crc_err on corrupt address", crc_err, eerr);
            end
        endcase
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        wr_cnt = 0; wr_bad = 0; rd_cnt = 0; exp_base = 0;
        wait_cyc(3);
        chk("R9", "busy in reset", busy, 0);
        chk("R9", "mem_we in reset", mem_we, 0);
        rst_n = 1;
        cs_n  = 0;
        @(negedge clk);
        chk("R9", "crc_err after reset", crc_err, 0);
        chk("R9", "out_valid after reset", out_valid, 0);
        chk("R9", "in_ready after reset", in_ready, 0);

        for (int i = 0; i < 6; i++) run_case(CASES[i]);

        // R5: explicit clear
        clr_err = 1;
        @(negedge clk);
        clr_err = 0;
        chk("R5", "crc_err after clear pulse", crc_err, 0);

        // R7: busy duration and in_ready during the copy
        begin
            logic [15:0] c = 16'hFFFF;
            int nb = 0, rdy_busy = 0;
            wr_cnt = 0; wr_bad = 0; exp_base = 24'h00A000;
            for (int k = 0; k < 128; k++) exp_data[k] = 8'(255 - k);
            for (int i = 2; i >= 0; i--) c = ref_crc(c, exp_base[i*8 +: 8]);
            for (int k = 0; k < 128; k++) c = ref_crc(c, exp_data[k]);
            pulse_start(0);
            for (int i = 2; i >= 0; i--) send_byte(exp_base[i*8 +: 8]);
            for (int k = 0; k < 128; k++) send_byte(exp_data[k]);
            send_byte(c[15:8]);
            send_byte(c[7:0]);
            for (int t = 0; t < 140; t++) begin
                if (busy) begin
                    nb++;
                    if (in_ready) rdy_busy++;
                end
                @(negedge clk);
            end
            chk("R7", "busy cycle count", nb, 128);
            chk("R7", "in_ready high while busy", rdy_busy, 0);
            chk("R2", "descending payload mismatches", wr_bad, 0);
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule